// File: doc/BRIEF.md
# Vectored Daisy-Chain Interrupt Controller

This block collects interrupt requests from a set of peripheral sources, ranks them by a fixed priority in which source 0 is the most urgent, and drives a single vectored-interrupt line to a 16-bit processor. Each source has a one-cycle request strobe. A strobe sets that source's pending bit, and the bit stays set until the source is acknowledged.

When the processor runs a vector-acknowledge cycle, the block returns the 16-bit vector of the best eligible source on the following cycle. It then marks that source as in service and consumes its pending request. A source in service holds back itself and every less urgent source, but more urgent sources can still interrupt, so handlers nest. The handler ends by writing the return code 0x4D to a byte port. That write releases the most urgent source currently in service.

Software programs one 16-bit vector per source through a small write port and controls which sources may interrupt through an enable mask.

Top module: `vint_chain_ctrl`

## Requirements
- R1: When more than one source is eligible, an acknowledge selects the one with the lowest index.
- R2: `irq_o` is high exactly when at least one source is eligible, meaning pending, enabled and not blocked. It follows state on the cycle after the event that changed it.
- R3: On the cycle after `ack_i` is high, `vec_o` holds the programmed vector of the selected source. If no source is eligible, `vec_o` is 0 and no state changes. `vec_o` holds its value between acknowledges.
- R4: An acknowledge marks the selected source in service and clears its pending bit, so that request is not granted a second time.
- R5: While a source is in service, that source and every higher-index source are blocked. Lower-index sources remain eligible, so handlers can nest.
- R6: A write on the return port with data 0x4D clears only the lowest-index in-service bit. Writes of any other data value have no effect.
- R7: Bit i of the enable mask, written as a whole through `en_we_i`/`en_data_i`, gates source i. A disabled source keeps its pending request and becomes eligible once it is enabled.
- R8: Reset clears all pending bits, in-service bits, enables, vectors and `vec_o`, and holds `irq_o` low.
- R9: A vector write loads `vec_wdata_i` into the vector of source `vec_idx_i`. The next acknowledge that selects that source returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NSRC | One-cycle request strobe per source; bit 0 has the highest priority |
| en_we_i | input | 1 | Load the enable mask |
| en_data_i | input | NSRC | New enable mask |
| vec_we_i | input | 1 | Write one vector register |
| vec_idx_i | input | IDXW | Source index for the vector write |
| vec_wdata_i | input | VW | Vector value to store |
| ack_i | input | 1 | Vector-acknowledge strobe |
| ret_we_i | input | 1 | Byte write on the return port |
| ret_data_i | input | 8 | Return port data; 0x4D ends service |
| irq_o | output | 1 | Vectored-interrupt request to the processor |
| vec_o | output | VW | Vector returned by the last acknowledge |

## Verification
The assertions assume that `ack_i`, the return write and the configuration writes are single-cycle strobes sampled on the rising edge. They also assume that `vec_idx_i` addresses an existing source whenever a vector write is made. The stimulus drives every strobe for exactly one cycle and never writes a vector index beyond the last source. It also never acknowledges and returns in the same cycle, which keeps the per-cycle in-service count checks unambiguous.

// File: rtl/vint_pkg.sv
package vint_pkg;
    localparam logic [7:0] RET_CODE = 8'h4D;
    localparam int unsigned PORT_W = 8;
endpackage

// File: rtl/vint_prio.sv
module vint_prio #(
    parameter int unsigned N    = 7,
    parameter int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    pend,
    input  logic [N-1:0]    en,
    input  logic [N-1:0]    isr,
    output logic [N-1:0]    grant,
    output logic [IDXW-1:0] grant_idx,
    output logic            any
);
    logic [N-1:0] blk;
    logic [N-1:0] elig;
    logic [N:0]   seen;

    assign seen[0] = 1'b0;

    // blocked = some in-service bit at this index or any lower index
    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            if (i == 0) begin : g_first
                assign blk[i] = isr[i];
            end else begin : g_rest
                assign blk[i] = blk[i-1] | isr[i];
            end
            assign elig[i]   = pend[i] & en[i] & ~blk[i];
            assign grant[i]  = elig[i] & ~seen[i];
            assign seen[i+1] = seen[i] | elig[i];
        end
    endgenerate

    assign any = seen[N];

    always_comb begin
        grant_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (grant[i]) grant_idx = IDXW'(i);
        end
    end

    // R1: at most one winner, and only from enabled requesters
    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~(pend & en)) == '0));
endmodule

// File: rtl/vint_vec_bank.sv
module vint_vec_bank #(
    parameter int unsigned N    = 7,
    parameter int unsigned VW   = 16,
    parameter int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDXW-1:0] widx,
    input  logic [VW-1:0]   wdata,
    input  logic [IDXW-1:0] ridx,
    output logic [VW-1:0]   rdata
);
    logic [VW-1:0] vec_d [N];
    logic [VW-1:0] vec_q [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            vec_d[i] = vec_q[i];
            if (we && (widx == IDXW'(i))) vec_d[i] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) vec_q[i] <= '0;
            else        vec_q[i] <= vec_d[i];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (ridx == IDXW'(i)) rdata = vec_q[i];
        end
    end

    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we && (int'(widx) < N) |=> (vec_q[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/vint_isr_track.sv
module vint_isr_track #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ack_set,
    input  logic         ret_hit,
    output logic [N-1:0] isr
);
    logic [N-1:0] isr_d;
    logic [N-1:0] isr_q;
    logic [N-1:0] lowest;

    assign lowest = isr_q & (~isr_q + N'(1));

    always_comb begin
        isr_d = isr_q;
        if (ret_hit) isr_d = isr_d & ~lowest;
        isr_d = isr_d | ack_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_d;
    end

    assign isr = isr_q;

    assert_ack_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_set != '0) && !ret_hit |=>
            ($countones(isr_q) == $countones($past(isr_q)) + 1));
    assert_ret_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_hit && (ack_set == '0) && (isr_q != '0) |=>
            ($countones(isr_q) + 1 == $countones($past(isr_q))) &&
            ((isr_q & ~$past(isr_q)) == '0));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_hit && (ack_set == '0) |=> $stable(isr_q));
endmodule

// File: rtl/vint_chain_ctrl.sv
module vint_chain_ctrl #(
    parameter int unsigned NSRC = 7,
    parameter int unsigned VW   = 16,
    localparam int unsigned IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic            en_we_i,
    input  logic [NSRC-1:0] en_data_i,
    input  logic            vec_we_i,
    input  logic [IDXW-1:0] vec_idx_i,
    input  logic [VW-1:0]   vec_wdata_i,
    input  logic            ack_i,
    input  logic            ret_we_i,
    input  logic [7:0]      ret_data_i,
    output logic            irq_o,
    output logic [VW-1:0]   vec_o
);
    import vint_pkg::*;

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] en;
        logic [VW-1:0]   vec;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NSRC-1:0] grant;
    logic [IDXW-1:0] grant_idx;
    logic            any;
    logic [NSRC-1:0] isr;
    logic [VW-1:0]   vec_rd;
    logic [NSRC-1:0] ack_set;
    logic            ret_hit;

    assign ret_hit = ret_we_i && (ret_data_i == RET_CODE);
    assign ack_set = ack_i ? grant : '0;

    vint_prio #(.N(NSRC), .IDXW(IDXW)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (ctl_q.pend),
        .en        (ctl_q.en),
        .isr       (isr),
        .grant     (grant),
        .grant_idx (grant_idx),
        .any       (any)
    );

    vint_vec_bank #(.N(NSRC), .VW(VW), .IDXW(IDXW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (vec_we_i),
        .widx  (vec_idx_i),
        .wdata (vec_wdata_i),
        .ridx  (grant_idx),
        .rdata (vec_rd)
    );

    vint_isr_track #(.N(NSRC)) u_isr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_set (ack_set),
        .ret_hit (ret_hit),
        .isr     (isr)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (ack_i) begin
            ctl_d.pend = ctl_q.pend & ~grant;
            ctl_d.vec  = any ? vec_rd : '0;
        end
        ctl_d.pend = ctl_d.pend | req_i;
        if (en_we_i) ctl_d.en = en_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign irq_o = any;
    assign vec_o = ctl_q.vec;

    assert_irq_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((ctl_q.pend & ctl_q.en) != '0));
    assert_empty_ack_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i && !irq_o |=> (vec_o == '0));
    assert_vec_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> $stable(vec_o));
    assert_ack_consumes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i && irq_o && ((req_i & grant) == '0) |=>
            ($countones(ctl_q.pend) <= $countones($past(ctl_q.pend | req_i)) - 1));
endmodule

// File: tb/vint_chain_ctrl_test.sv
module vint_chain_ctrl_test;
    localparam int N  = 7;
    localparam int VW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_i = '0;
    logic          en_we_i = 1'b0;
    logic [N-1:0]  en_data_i = '0;
    logic          vec_we_i = 1'b0;
    logic [2:0]    vec_idx_i = '0;
    logic [VW-1:0] vec_wdata_i = '0;
    logic          ack_i = 1'b0;
    logic          ret_we_i = 1'b0;
    logic [7:0]    ret_data_i = '0;
    logic          irq_o;
    logic [VW-1:0] vec_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [VW-1:0] exp_q[$];
    string         tag_q[$];

    always #2 clk = ~clk;

    vint_chain_ctrl #(.NSRC(N), .VW(VW)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .en_we_i(en_we_i), .en_data_i(en_data_i),
        .vec_we_i(vec_we_i), .vec_idx_i(vec_idx_i), .vec_wdata_i(vec_wdata_i),
        .ack_i(ack_i), .ret_we_i(ret_we_i), .ret_data_i(ret_data_i),
        .irq_o(irq_o), .vec_o(vec_o)
    );

    function automatic logic [VW-1:0] vval(int i);
        return 16'hC100 + 16'(i) * 16'h0111;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares vec_o after each acknowledge with the queued expectation
    initial begin
        forever begin
            logic was;
            @(posedge clk);
            was = ack_i;
            @(negedge clk);
            if (was) begin
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R3 unexpected ack actual=%h expected=none", vec_o);
                end else begin
                    chk(tag_q.pop_front(), 32'(vec_o), 32'(exp_q.pop_front()));
                end
            end
        end
    end

    task automatic do_ack(logic [VW-1:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic pulse(logic [N-1:0] m);
        req_i = m;
        @(negedge clk);
        req_i = '0;
    endtask

    task automatic set_en(logic [N-1:0] m);
        en_we_i = 1'b1; en_data_i = m;
        @(negedge clk);
        en_we_i = 1'b0;
    endtask

    task automatic set_vec(int i, logic [VW-1:0] v);
        vec_we_i = 1'b1; vec_idx_i = 3'(i); vec_wdata_i = v;
        @(negedge clk);
        vec_we_i = 1'b0;
    endtask

    task automatic ret(logic [7:0] d);
        ret_we_i = 1'b1; ret_data_i = d;
        @(negedge clk);
        ret_we_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 irq after reset", 32'(irq_o), 0);
        chk("R8 vec after reset", 32'(vec_o), 0);
        do_ack('0, "R3 ack with nothing eligible");

        for (int i = 0; i < N; i++) set_vec(i, vval(i));
        set_en('1);
        chk("R2 idle irq", 32'(irq_o), 0);

        pulse(7'b0101000);
        chk("R2 irq with requests", 32'(irq_o), 1);
        do_ack(vval(3), "R1 lower index wins");
        chk("R5 lower priority blocked", 32'(irq_o), 0);
        pulse(7'b0000010);
        chk("R5 higher priority nests", 32'(irq_o), 1);
        do_ack(vval(1), "R4 nested ack");
        chk("R4 request consumed", 32'(irq_o), 0);
        ret(8'h4D);
        chk("R6 lowest in-service cleared only", 32'(irq_o), 0);
        ret(8'h4C);
        chk("R6 other code ignored", 32'(irq_o), 0);
        ret(8'h4D);
        chk("R6 release unblocks", 32'(irq_o), 1);
        do_ack(vval(5), "R5 blocked source after release");
        do_ack('0, "R3 ack while blocked returns zero");
        chk("R3 vec holds", 32'(vec_o), 0);
        ret(8'h4D);
        chk("R4 all consumed", 32'(irq_o), 0);

        set_en(7'b1111011);
        pulse(7'b0000100);
        chk("R7 disabled source silent", 32'(irq_o), 0);
        do_ack('0, "R7 disabled not acked");
        set_en('1);
        chk("R7 pending kept", 32'(irq_o), 1);
        do_ack(vval(2), "R7 enabled later");
        ret(8'h4D);

        pulse(7'b1010001);
        do_ack(vval(0), "R1 order first");
        ret(8'h4D);
        do_ack(vval(4), "R1 order second");
        ret(8'h4D);
        do_ack(vval(6), "R1 order third");
        ret(8'h4D);
        chk("R4 chain drained", 32'(irq_o), 0);

        set_vec(6, 16'h1234);
        pulse(7'b1000000);
        do_ack(16'h1234, "R9 reprogrammed vector");
        ret(8'h4D);

        pulse(7'b0010000);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 irq after mid reset", 32'(irq_o), 0);
        chk("R8 vec after mid reset", 32'(vec_o), 0);
        set_en('1);
        chk("R8 pending cleared", 32'(irq_o), 0);
        do_ack('0, "R8 vectors cleared");

        repeat (3) @(negedge clk);
        chk("R3 scoreboard drained", 32'(exp_q.size()), 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule